// File: doc/BRIEF.md
# Indirect Mailbox Register Port

This block lets a slow host bus reach a large bank of inner registers through only two host-visible locations. The host first writes the number of the wanted inner register into the index location. It then reads or writes that register through the data location. The block turns each index write into a fetch request and each data write into a store request. Both requests go to an inner-side agent, which may take any number of cycles to answer.

Host reads are always answered in the same cycle from registers the block already holds. A read never waits on the inner agent. The host polls a ready flag, which is bit 7 of the index location, to learn when the staged value is valid. Writing a new index while a fetch is still open replaces that request. A late answer that carries the old index is dropped.

Top module: `mbox_port`

## Requirements
- R1: After reset the index is 0, the ready flag is 0, `in_req` is low, and a read of offset 0 returns 0.
- R2: A host write to offset 0 latches `hst_wdata[6:0]` as the index. A read of offset 0 returns the ready flag in bit 7 and the index in bits 6:0.
- R3: One cycle after an index write, `in_req` is high, `in_we` is low, and `in_idx` equals the new index. The ready flag is cleared.
- R4: While a request is open, a response (`in_rsp_valid`) whose `in_rsp_idx` equals the current index closes the request. One cycle later `in_req` is low and ready is 1. For a fetch, `in_rsp_data` becomes the staged data.
- R5: A read of offset 4 returns the staged data in the same cycle with no side effect on the request state.
- R6: A host write to offset 4 raises a store request one cycle later: `in_req` high, `in_we` high, `in_wdata` set to the written byte. Ready stays 0 until the response comes back. After that response, the staged data equals the written byte.
- R7: An index write while a request is open cancels that request and opens a fetch for the new index. A response whose index does not match the current index is ignored: `in_req` stays high and ready stays 0.
- R8: Host accesses to any offset other than 0 and 4 have no effect. Reads of such offsets return 0.
- R9: A response that arrives while no request is open changes nothing.
- R10: If a host write and a matching response land in the same cycle, the host write wins and the response is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_en | input | 1 | Host access strobe |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | 3 | Host byte offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational |
| in_req | output | 1 | Inner request open |
| in_we | output | 1 | Open request is a store |
| in_idx | output | 7 | Inner register index of the request |
| in_wdata | output | 8 | Store data |
| in_rsp_valid | input | 1 | Inner response pulse |
| in_rsp_idx | input | 7 | Index the response belongs to |
| in_rsp_data | input | 8 | Fetched value |

## Verification
The hardest case to reach is a stale response: an answer that arrives after the host has already moved to another index. It must be dropped while the newer request stays open. The bench reaches this case by writing two indices back to back. It then plays the inner agent itself and answers the first, cancelled index before the second. A related race is a host write and a matching response in the same cycle. The bench drives both in one cycle and checks that the host's store stays pending.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [1:0] {
      LOC_NONE = 2'd0,
      LOC_IDX  = 2'd1,
      LOC_DAT  = 2'd2
   } loc_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
   import mbox_pkg::*;
#(
   parameter int AW      = 3,
   parameter int IDX_OFS = 0,
   parameter int DAT_OFS = 4
) (
   input  logic [AW-1:0] addr,
   output loc_e          loc
);
   localparam logic [AW-1:0] A_IDX = AW'(IDX_OFS);
   localparam logic [AW-1:0] A_DAT = AW'(DAT_OFS);

   always_comb begin
      if (addr == A_IDX)      loc = LOC_IDX;
      else if (addr == A_DAT) loc = LOC_DAT;
      else                    loc = LOC_NONE;
   end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
   parameter int DW = 8,
   parameter int IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_idx,
   input  logic          wr_dat,
   input  logic [DW-1:0] wdata,
   input  logic          rsp_valid,
   input  logic [IW-1:0] rsp_idx,
   input  logic [DW-1:0] rsp_data,
   output logic [IW-1:0] idx_q,
   output logic          pend_q,
   output logic          we_q,
   output logic [DW-1:0] wd_q,
   output logic          rdy_q,
   output logic [DW-1:0] stage_q
);
   logic rsp_hit;

   assign rsp_hit = rsp_valid && pend_q && (rsp_idx == idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         pend_q  <= 1'b0;
         we_q    <= 1'b0;
         wd_q    <= '0;
         rdy_q   <= 1'b0;
         stage_q <= '0;
      end else if (wr_idx) begin
         idx_q  <= wdata[IW-1:0];
         pend_q <= 1'b1;
         we_q   <= 1'b0;
         rdy_q  <= 1'b0;
      end else if (wr_dat) begin
         pend_q <= 1'b1;
         we_q   <= 1'b1;
         wd_q   <= wdata;
         rdy_q  <= 1'b0;
      end else if (rsp_hit) begin
         pend_q  <= 1'b0;
         rdy_q   <= 1'b1;
         stage_q <= we_q ? wd_q : rsp_data;
      end
   end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
   import mbox_pkg::*;
#(
   parameter int DW      = 8,
   parameter int IW      = 7,
   parameter int AW      = 3,
   parameter int IDX_OFS = 0,
   parameter int DAT_OFS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_en,
   input  logic          hst_we,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   output logic [DW-1:0] hst_rdata,
   output logic          in_req,
   output logic          in_we,
   output logic [IW-1:0] in_idx,
   output logic [DW-1:0] in_wdata,
   input  logic          in_rsp_valid,
   input  logic [IW-1:0] in_rsp_idx,
   input  logic [DW-1:0] in_rsp_data
);
   localparam int PAD_W = DW - IW - 1;

   generate
      if (IW + 1 > DW) begin : g_bad_width
         $error("mbox_port: index plus ready flag must fit in DW");
      end
      if (IDX_OFS == DAT_OFS) begin : g_bad_ofs
         $error("mbox_port: index and data offsets must differ");
      end
      if (IDX_OFS >= (1 << AW) || DAT_OFS >= (1 << AW)) begin : g_bad_aw
         $error("mbox_port: offsets must fit in AW bits");
      end
   endgenerate

   loc_e          loc;
   logic          wr_idx, wr_dat, rd_en;
   logic [IW-1:0] idx_q;
   logic          pend_q, we_q, rdy_q;
   logic [DW-1:0] wd_q, stage_q, status;

   mbox_decode #(.AW(AW), .IDX_OFS(IDX_OFS), .DAT_OFS(DAT_OFS)) u_dec (
      .addr (hst_addr),
      .loc  (loc)
   );

   assign wr_idx = hst_en && hst_we && (loc == LOC_IDX);
   assign wr_dat = hst_en && hst_we && (loc == LOC_DAT);
   assign rd_en  = hst_en && !hst_we;

   mbox_ctrl #(.DW(DW), .IW(IW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_idx    (wr_idx),
      .wr_dat    (wr_dat),
      .wdata     (hst_wdata),
      .rsp_valid (in_rsp_valid),
      .rsp_idx   (in_rsp_idx),
      .rsp_data  (in_rsp_data),
      .idx_q     (idx_q),
      .pend_q    (pend_q),
      .we_q      (we_q),
      .wd_q      (wd_q),
      .rdy_q     (rdy_q),
      .stage_q   (stage_q)
   );

   // ready flag sits just above the index; any spare bits read as zero
   generate
      if (PAD_W > 0) begin : g_pad
         assign status = {{PAD_W{1'b0}}, rdy_q, idx_q};
      end else begin : g_nopad
         assign status = {rdy_q, idx_q};
      end
   endgenerate

   always_comb begin
      hst_rdata = '0;
      if (rd_en) begin
         unique case (loc)
            LOC_IDX: hst_rdata = status;
            LOC_DAT: hst_rdata = stage_q;
            default: hst_rdata = '0;
         endcase
      end
   end

   assign in_req   = pend_q;
   assign in_we    = we_q;
   assign in_idx   = idx_q;
   assign in_wdata = wd_q;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk #(
   parameter int DW      = 8,
   parameter int IW      = 7,
   parameter int AW      = 3,
   parameter int IDX_OFS = 0,
   parameter int DAT_OFS = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hst_en,
   input logic          hst_we,
   input logic [AW-1:0] hst_addr,
   input logic [DW-1:0] hst_wdata,
   input logic [DW-1:0] hst_rdata,
   input logic          in_req,
   input logic          in_we,
   input logic [IW-1:0] in_idx,
   input logic [DW-1:0] in_wdata,
   input logic          in_rsp_valid,
   input logic [IW-1:0] in_rsp_idx,
   input logic          rdy
);
   localparam logic [AW-1:0] A_IDX = AW'(IDX_OFS);
   localparam logic [AW-1:0] A_DAT = AW'(DAT_OFS);

   logic h_idx, h_dat, h_any, h_odd, hit;
   assign h_idx = hst_en && hst_we && (hst_addr == A_IDX);
   assign h_dat = hst_en && hst_we && (hst_addr == A_DAT);
   assign h_any = h_idx || h_dat;
   assign h_odd = hst_en && (hst_addr != A_IDX) && (hst_addr != A_DAT);
   assign hit   = in_req && in_rsp_valid && (in_rsp_idx == in_idx);

   a_r3_fetch_req: assert property (@(posedge clk) disable iff (!rst_n)
      h_idx |=> in_req && !in_we && !rdy && (in_idx == $past(hst_wdata[IW-1:0])));

   a_r6_store_req: assert property (@(posedge clk) disable iff (!rst_n)
      h_dat |=> in_req && in_we && !rdy && (in_wdata == $past(hst_wdata)));

   a_r4_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !h_any) |=> !in_req && rdy);

   a_r7_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_req && in_rsp_valid && (in_rsp_idx != in_idx) && !h_any)
         |=> in_req && !rdy && $stable(in_idx));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_req && !h_any) |=> !in_req && $stable(in_idx) && $stable(rdy));

   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (h_odd && !hst_we) |-> hst_rdata == '0);

   a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && h_dat) |=> in_req && in_we);
endmodule

bind mbox_port mbox_port_chk #(
   .DW(DW), .IW(IW), .AW(AW), .IDX_OFS(IDX_OFS), .DAT_OFS(DAT_OFS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hst_en       (hst_en),
   .hst_we       (hst_we),
   .hst_addr     (hst_addr),
   .hst_wdata    (hst_wdata),
   .hst_rdata    (hst_rdata),
   .in_req       (in_req),
   .in_we        (in_we),
   .in_idx       (in_idx),
   .in_wdata     (in_wdata),
   .in_rsp_valid (in_rsp_valid),
   .in_rsp_idx   (in_rsp_idx),
   .rdy          (rdy_q)
);

// File: tb/mbox_port_tb.sv
`timescale 1ns/1ps
module mbox_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_en = 1'b0, hst_we = 1'b0;
   logic [2:0] hst_addr = '0;
   logic [7:0] hst_wdata = '0;
   logic [7:0] hst_rdata;
   logic       in_req, in_we;
   logic [6:0] in_idx;
   logic [7:0] in_wdata;
   logic       in_rsp_valid = 1'b0;
   logic [6:0] in_rsp_idx = '0;
   logic [7:0] in_rsp_data = '0;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mbox_port u_dut (
      .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .in_req(in_req), .in_we(in_we), .in_idx(in_idx), .in_wdata(in_wdata),
      .in_rsp_valid(in_rsp_valid), .in_rsp_idx(in_rsp_idx),
      .in_rsp_data(in_rsp_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock with the given host and response stimulus; returns at the next negedge
   task automatic step(input logic en, input logic we, input logic [2:0] a,
                       input logic [7:0] wd, input logic rv,
                       input logic [6:0] ri, input logic [7:0] rd);
      hst_en = en; hst_we = we; hst_addr = a; hst_wdata = wd;
      in_rsp_valid = rv; in_rsp_idx = ri; in_rsp_data = rd;
      @(posedge clk);
      @(negedge clk);
      hst_en = 1'b0; hst_we = 1'b0; in_rsp_valid = 1'b0;
   endtask

   task automatic hwr(input logic [2:0] a, input logic [7:0] d);
      step(1'b1, 1'b1, a, d, 1'b0, '0, '0);
   endtask

   task automatic rsp(input logic [6:0] i, input logic [7:0] d);
      step(1'b0, 1'b0, '0, '0, 1'b1, i, d);
   endtask

   task automatic hrd(input logic [2:0] a, output logic [7:0] d);
      hst_en = 1'b1; hst_we = 1'b0; hst_addr = a;
      #1 d = hst_rdata;
      hst_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      hrd(3'd0, d);
      chk("R1 status", d, 8'h00);
      chk("R1 in_req", in_req, 1'b0);
   endtask

   task automatic t_fetch;
      logic [7:0] d;
      hwr(3'd0, 8'h05);
      chk("R3 in_req", in_req, 1'b1);
      chk("R3 in_we", in_we, 1'b0);
      chk("R3 in_idx", in_idx, 7'h05);
      hrd(3'd0, d);
      chk("R2 status busy", d, 8'h05);
      repeat (3) @(negedge clk);
      chk("R3 req held", in_req, 1'b1);
      rsp(7'h05, 8'hA7);
      chk("R4 req closed", in_req, 1'b0);
      hrd(3'd0, d);
      chk("R4 status ready", d, 8'h85);
      hrd(3'd4, d);
      chk("R5 staged data", d, 8'hA7);
      hrd(3'd4, d);
      chk("R5 read again", d, 8'hA7);
      chk("R5 no side effect", in_req, 1'b0);
   endtask

   task automatic t_store;
      logic [7:0] d;
      hwr(3'd4, 8'h3C);
      chk("R6 in_req", in_req, 1'b1);
      chk("R6 in_we", in_we, 1'b1);
      chk("R6 in_wdata", in_wdata, 8'h3C);
      hrd(3'd0, d);
      chk("R6 ready cleared", d, 8'h05);
      rsp(7'h05, 8'hEE);
      hrd(3'd0, d);
      chk("R6 ready after ack", d, 8'h85);
      hrd(3'd4, d);
      chk("R6 staged store", d, 8'h3C);
   endtask

   task automatic t_cancel;
      logic [7:0] d;
      hwr(3'd0, 8'h09);
      hwr(3'd0, 8'h0C);
      chk("R7 new idx", in_idx, 7'h0C);
      rsp(7'h09, 8'h11);
      chk("R7 still pending", in_req, 1'b1);
      hrd(3'd0, d);
      chk("R7 stale dropped", d, 8'h0C);
      rsp(7'h0C, 8'h22);
      hrd(3'd0, d);
      chk("R7 new done", d, 8'h8C);
      hrd(3'd4, d);
      chk("R7 new data", d, 8'h22);
   endtask

   task automatic t_idle_rsp;
      logic [7:0] d;
      rsp(7'h0C, 8'h55);
      hrd(3'd4, d);
      chk("R9 data kept", d, 8'h22);
      chk("R9 no req", in_req, 1'b0);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      hwr(3'd2, 8'h7F);
      chk("R8 no req", in_req, 1'b0);
      hrd(3'd0, d);
      chk("R8 status kept", d, 8'h8C);
      hrd(3'd2, d);
      chk("R8 read zero", d, 8'h00);
      hrd(3'd4, d);
      chk("R8 data kept", d, 8'h22);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      hwr(3'd0, 8'h03);
      step(1'b1, 1'b1, 3'd4, 8'h66, 1'b1, 7'h03, 8'h99);
      chk("R10 req open", in_req, 1'b1);
      chk("R10 store pending", in_we, 1'b1);
      hrd(3'd0, d);
      chk("R10 not ready", d, 8'h03);
      rsp(7'h03, 8'h99);
      hrd(3'd4, d);
      chk("R10 store wins", d, 8'h66);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fetch();
      t_store();
      t_cancel();
      t_idle_rsp();
      t_unmapped();
      t_collide();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule